// File: doc/BRIEF.md
# Command Header Stream Parser

This block sits behind a single 32-bit command register. Software writes a header word followed by a variable number of payload words to the same address. The parser decodes the header into a command code, a payload word count, an entropy-source flag and a generate length. It then gathers the announced payload words and offers the finished command to a downstream engine over a valid/ready handshake.

The parser exposes three status lines: ready, busy and error. A header with an unknown command code, or a generate command that asks for zero blocks, raises the error line. The payload words that such a header announces are then consumed and dropped, so the word stream stays aligned. The next legal header clears the error.

Top module: `cmd_hdr_parser`

## Requirements
- R1: A header write is decoded from these bit fields: bits [3:0] command code (1 instantiate, 2 reseed, 3 generate, 4 update, 5 uninstantiate), bits [7:4] payload word count (0 to 15), bit 8 entropy flag, bits [30:12] generate length in 128-bit blocks. The fields appear on `cmd_code`, `cmd_nwords`, `cmd_entropy`, `cmd_glen` while `cmd_valid` is high.
- R2: The payload writes that follow a legal header are stored in arrival order, with word i on `cmd_payload[32*i +: 32]`. Slots beyond the announced count read zero.
- R3: `cmd_valid` rises in the cycle after the header write when the count is 0, or else in the cycle after the last payload write. It stays high with all command fields stable until a cycle with `cmd_ready` high.
- R4: While payload words are still expected, every write is stored as payload and is never decoded as a header, even if it looks like a header.
- R5: A header with command code 0 or above 5 sets `sts_error`, produces no `cmd_valid`, and causes the announced number of following writes to be discarded. The write after those is decoded as a header.
- R6: A generate header (code 3) with a generate length of 0 is treated as illegal, exactly as in R5.
- R7: Error takes precedence over ready: `sts_ready` is low whenever `sts_error` is high. `sts_error` stays high until a legal header is written, which clears it in the same cycle it is accepted.
- R8: `sts_busy` is high from the cycle after a header write until the cycle after the downstream engine accepts the command (or the last discarded word is consumed). Out of reset the parser shows ready high, busy low and error low.
- R9: Writes that arrive while a command is being offered are ignored: the offered command and its payload do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the command register |
| wr_data | input | 32 | Write data: a header or a payload word |
| cmd_valid | output | 1 | Assembled command is offered |
| cmd_ready | input | 1 | Downstream engine accepts the command |
| cmd_code | output | 4 | Command code |
| cmd_nwords | output | 4 | Number of payload words |
| cmd_entropy | output | 1 | Entropy source flag |
| cmd_glen | output | 19 | Generate length in 128-bit blocks |
| cmd_payload | output | 480 | Payload words, word i in bits [32*i +: 32] |
| sts_ready | output | 1 | Idle, no error, next write is a header |
| sts_busy | output | 1 | A command is being collected, offered or discarded |
| sts_error | output | 1 | Last header was illegal |

## Verification
On every cycle, the assertions check several properties. An offered command holds still until it is accepted, carries only a legal code and never a zero-length generate, and coincides with busy. Error always masks ready, and busy drops right after a handshake. Only the directed scenarios can show that the header bit fields and payload order are decoded correctly. They also cover a header-like payload word being taken as data, the right number of words being swallowed after an illegal header, and stray writes during an offer leaving the command untouched.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;

    localparam int WORD_W    = 32;
    localparam int CODE_W    = 4;
    localparam int LEN_W     = 4;
    localparam int GLEN_W    = 19;
    localparam int MAX_WORDS = (1 << LEN_W) - 1;

    typedef enum logic [CODE_W-1:0] {
        OP_NONE    = 4'd0,
        OP_INST    = 4'd1,
        OP_RESEED  = 4'd2,
        OP_GEN     = 4'd3,
        OP_UPDATE  = 4'd4,
        OP_UNINST  = 4'd5
    } op_e;

    typedef struct packed {
        logic [GLEN_W-1:0] glen;
        logic              entropy;
        logic [LEN_W-1:0]  nwords;
        logic [CODE_W-1:0] code;
    } hdr_t;

    typedef enum logic [1:0] {
        PS_IDLE,
        PS_COLLECT,
        PS_DISCARD,
        PS_OFFER
    } pstate_e;

    function automatic hdr_t split_header(input logic [WORD_W-1:0] w);
        hdr_t h;
        h.code    = w[3:0];
        h.nwords  = w[7:4];
        h.entropy = w[8];
        h.glen    = w[30:12];
        return h;
    endfunction

    function automatic logic header_legal(input hdr_t h);
        logic known;
        known = (h.code >= OP_INST) && (h.code <= OP_UNINST);
        if (h.code == OP_GEN && h.glen == '0) begin
            known = 1'b0;
        end
        return known;
    endfunction

endpackage

// File: rtl/cmdp_hdr_decode.sv
module cmdp_hdr_decode
    import cmdp_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output hdr_t              hdr,
    output logic              legal
);
    always_comb begin
        hdr   = split_header(word);
        legal = header_legal(hdr);
    end
endmodule

// File: rtl/cmdp_seq.sv
module cmdp_seq
    import cmdp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  hdr_t             hdr_in,
    input  logic             hdr_ok,
    input  logic             take,
    output pstate_e          state,
    output hdr_t             hdr_q,
    output logic             err_q,
    output logic             hdr_stb,
    output logic             pay_stb,
    output logic [LEN_W-1:0] pay_idx
);
    logic [LEN_W-1:0] remain;

    assign hdr_stb = wr_en && (state == PS_IDLE);
    assign pay_stb = wr_en && (state == PS_COLLECT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PS_IDLE;
            hdr_q   <= '0;
            err_q   <= 1'b0;
            remain  <= '0;
            pay_idx <= '0;
        end else begin
            unique case (state)
                PS_IDLE: begin
                    if (wr_en) begin
                        hdr_q   <= hdr_in;
                        remain  <= hdr_in.nwords;
                        pay_idx <= '0;
                        if (hdr_ok) begin
                            err_q <= 1'b0;
                            state <= (hdr_in.nwords == '0) ? PS_OFFER : PS_COLLECT;
                        end else begin
                            err_q <= 1'b1;
                            state <= (hdr_in.nwords == '0) ? PS_IDLE : PS_DISCARD;
                        end
                    end
                end
                PS_COLLECT: begin
                    if (wr_en) begin
                        pay_idx <= pay_idx + 1'b1;
                        remain  <= remain - 1'b1;
                        if (remain == LEN_W'(1)) begin
                            state <= PS_OFFER;
                        end
                    end
                end
                PS_DISCARD: begin
                    if (wr_en) begin
                        remain <= remain - 1'b1;
                        if (remain == LEN_W'(1)) begin
                            state <= PS_IDLE;
                        end
                    end
                end
                PS_OFFER: begin
                    if (take) begin
                        state <= PS_IDLE;
                    end
                end
                default: state <= PS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cmdp_payload_store.sv
module cmdp_payload_store
    import cmdp_pkg::*;
#(
    parameter int DEPTH = MAX_WORDS,
    parameter int IDX_W = LEN_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic                    wr,
    input  logic [IDX_W-1:0]        idx,
    input  logic [WORD_W-1:0]       data,
    output logic [DEPTH*WORD_W-1:0] flat
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [WORD_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                slot_q <= '0;
            end else if (wr && idx == IDX_W'(g)) begin
                slot_q <= data;
            end
        end
        assign flat[g*WORD_W +: WORD_W] = slot_q;
    end
endmodule

// File: rtl/cmd_hdr_parser.sv
module cmd_hdr_parser
    import cmdp_pkg::*;
#(
    parameter int PAY_WORDS = MAX_WORDS
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [WORD_W-1:0]           wr_data,
    output logic                        cmd_valid,
    input  logic                        cmd_ready,
    output logic [CODE_W-1:0]           cmd_code,
    output logic [LEN_W-1:0]            cmd_nwords,
    output logic                        cmd_entropy,
    output logic [GLEN_W-1:0]           cmd_glen,
    output logic [PAY_WORDS*WORD_W-1:0] cmd_payload,
    output logic                        sts_ready,
    output logic                        sts_busy,
    output logic                        sts_error
);
    hdr_t             dec_hdr;
    logic             dec_ok;
    pstate_e          state;
    hdr_t             hdr_q;
    logic             err_q;
    logic             hdr_stb;
    logic             pay_stb;
    logic [LEN_W-1:0] pay_idx;

    cmdp_hdr_decode i_dec (
        .word  (wr_data),
        .hdr   (dec_hdr),
        .legal (dec_ok)
    );

    cmdp_seq i_seq (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .hdr_in  (dec_hdr),
        .hdr_ok  (dec_ok),
        .take    (cmd_ready),
        .state   (state),
        .hdr_q   (hdr_q),
        .err_q   (err_q),
        .hdr_stb (hdr_stb),
        .pay_stb (pay_stb),
        .pay_idx (pay_idx)
    );

    cmdp_payload_store #(
        .DEPTH (PAY_WORDS),
        .IDX_W (LEN_W)
    ) i_store (
        .clk   (clk),
        .rst   (rst),
        .clear (hdr_stb),
        .wr    (pay_stb),
        .idx   (pay_idx),
        .data  (wr_data),
        .flat  (cmd_payload)
    );

    assign cmd_valid   = (state == PS_OFFER);
    assign cmd_code    = hdr_q.code;
    assign cmd_nwords  = hdr_q.nwords;
    assign cmd_entropy = hdr_q.entropy;
    assign cmd_glen    = hdr_q.glen;
    assign sts_busy    = (state != PS_IDLE);
    assign sts_error   = err_q;
    assign sts_ready   = (state == PS_IDLE) && !err_q;
endmodule

// File: rtl/cmd_hdr_parser_chk.sv
module cmd_hdr_parser_chk
    import cmdp_pkg::*;
#(
    parameter int PAY_WORDS = MAX_WORDS
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        cmd_valid,
    input logic                        cmd_ready,
    input logic [CODE_W-1:0]           cmd_code,
    input logic [GLEN_W-1:0]           cmd_glen,
    input logic [PAY_WORDS*WORD_W-1:0] cmd_payload,
    input logic                        sts_ready,
    input logic                        sts_busy,
    input logic                        sts_error
);
    AST_OFFER_HOLDS: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_code) && $stable(cmd_payload)); // R3

    AST_OFFER_LEGAL_CODE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_code >= 4'd1 && cmd_code <= 4'd5)); // R5

    AST_OFFER_GEN_NONZERO: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_code == 4'd3 |-> cmd_glen != '0); // R6

    AST_ERROR_MASKS_READY: assert property (@(posedge clk) disable iff (rst)
        sts_error |-> !sts_ready); // R7

    AST_OFFER_IS_BUSY: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> sts_busy && !sts_ready); // R8

    AST_ACCEPT_FREES: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_ready |=> !sts_busy && !cmd_valid); // R8
endmodule

bind cmd_hdr_parser cmd_hdr_parser_chk #(.PAY_WORDS(PAY_WORDS)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_code    (cmd_code),
    .cmd_glen    (cmd_glen),
    .cmd_payload (cmd_payload),
    .sts_ready   (sts_ready),
    .sts_busy    (sts_busy),
    .sts_error   (sts_error)
);

// File: tb/test_cmd_hdr_parser.sv
module test_cmd_hdr_parser;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [31:0]  wr_data = '0;
    logic         cmd_ready = 1'b0;
    logic         cmd_valid;
    logic [3:0]   cmd_code;
    logic [3:0]   cmd_nwords;
    logic         cmd_entropy;
    logic [18:0]  cmd_glen;
    logic [479:0] cmd_payload;
    logic         sts_ready, sts_busy, sts_error;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    cmd_hdr_parser i_cmd_hdr_parser (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_code(cmd_code),
        .cmd_nwords(cmd_nwords), .cmd_entropy(cmd_entropy), .cmd_glen(cmd_glen),
        .cmd_payload(cmd_payload), .sts_ready(sts_ready), .sts_busy(sts_busy),
        .sts_error(sts_error)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic accept();
        @(negedge clk);
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        chk("R8", "valid after accept", {31'd0, cmd_valid}, 32'd0);
        chk("R8", "busy after accept", {31'd0, sts_busy}, 32'd0);
    endtask

    function automatic logic [31:0] pw(input int i);
        return cmd_payload[32*i +: 32];
    endfunction

    task automatic t_reset();
        chk("R8", "ready out of reset", {31'd0, sts_ready}, 32'd1);
        chk("R8", "busy out of reset", {31'd0, sts_busy}, 32'd0);
        chk("R8", "error out of reset", {31'd0, sts_error}, 32'd0);
        chk("R3", "valid out of reset", {31'd0, cmd_valid}, 32'd0);
    endtask

    task automatic t_instantiate();
        wr(32'h0000_0121);
        chk("R8", "busy after header", {31'd0, sts_busy}, 32'd1);
        chk("R3", "no valid mid payload", {31'd0, cmd_valid}, 32'd0);
        wr(32'hA5A5_0001);
        wr(32'h1234_5678);
        chk("R3", "valid after last word", {31'd0, cmd_valid}, 32'd1);
        chk("R1", "code", {28'd0, cmd_code}, 32'd1);
        chk("R1", "nwords", {28'd0, cmd_nwords}, 32'd2);
        chk("R1", "entropy", {31'd0, cmd_entropy}, 32'd1);
        chk("R2", "word0", pw(0), 32'hA5A5_0001);
        chk("R2", "word1", pw(1), 32'h1234_5678);
        chk("R2", "word2 zero", pw(2), 32'h0);
        repeat (3) @(negedge clk);
        chk("R3", "valid held", {31'd0, cmd_valid}, 32'd1);
        wr(32'h0000_0015);
        chk("R9", "valid after stray", {31'd0, cmd_valid}, 32'd1);
        chk("R9", "code after stray", {28'd0, cmd_code}, 32'd1);
        chk("R9", "word0 after stray", pw(0), 32'hA5A5_0001);
        accept();
        chk("R8", "ready after accept", {31'd0, sts_ready}, 32'd1);
    endtask

    task automatic t_generate();
        wr(32'h0000_5003);
        chk("R3", "valid no payload", {31'd0, cmd_valid}, 32'd1);
        chk("R1", "code gen", {28'd0, cmd_code}, 32'd3);
        chk("R1", "glen", {13'd0, cmd_glen}, 32'd5);
        chk("R1", "entropy clear", {31'd0, cmd_entropy}, 32'd0);
        accept();
        wr(32'h7FFF_F003);
        chk("R1", "glen max", {13'd0, cmd_glen}, 32'h7FFFF);
        accept();
    endtask

    task automatic t_header_like_payload();
        wr(32'h0000_0012);
        wr(32'h0000_0003);
        chk("R4", "valid", {31'd0, cmd_valid}, 32'd1);
        chk("R4", "code stays reseed", {28'd0, cmd_code}, 32'd2);
        chk("R4", "payload kept", pw(0), 32'h0000_0003);
        chk("R2", "unused zero", pw(1), 32'h0);
        accept();
    endtask

    task automatic t_illegal_code();
        wr(32'h0000_0020);
        chk("R5", "error set", {31'd0, sts_error}, 32'd1);
        chk("R7", "ready masked", {31'd0, sts_ready}, 32'd0);
        chk("R5", "no valid", {31'd0, cmd_valid}, 32'd0);
        chk("R8", "busy discarding", {31'd0, sts_busy}, 32'd1);
        wr(32'h0000_0001);
        wr(32'h0000_5003);
        chk("R5", "no valid after discard", {31'd0, cmd_valid}, 32'd0);
        chk("R5", "idle after discard", {31'd0, sts_busy}, 32'd0);
        chk("R7", "error kept", {31'd0, sts_error}, 32'd1);
        wr(32'h0000_0005);
        chk("R5", "next is header", {31'd0, cmd_valid}, 32'd1);
        chk("R7", "error cleared", {31'd0, sts_error}, 32'd0);
        chk("R1", "uninstantiate", {28'd0, cmd_code}, 32'd5);
        accept();
        wr(32'h0000_0009);
        chk("R5", "code 9 error", {31'd0, sts_error}, 32'd1);
        chk("R5", "code 9 idle", {31'd0, sts_busy}, 32'd0);
    endtask

    task automatic t_zero_generate();
        wr(32'h0000_0003);
        chk("R6", "glen0 error", {31'd0, sts_error}, 32'd1);
        chk("R6", "glen0 no valid", {31'd0, cmd_valid}, 32'd0);
        wr(32'h0000_0014);
        chk("R7", "legal clears", {31'd0, sts_error}, 32'd0);
        wr(32'hCAFE_F00D);
        chk("R6", "update offered", {31'd0, cmd_valid}, 32'd1);
        chk("R2", "update word", pw(0), 32'hCAFE_F00D);
        accept();
        chk("R7", "ready back", {31'd0, sts_ready}, 32'd1);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                @(negedge clk);
                t_reset();
                t_instantiate();
                t_generate();
                t_header_like_payload();
                t_illegal_code();
                t_zero_generate();
            end
            begin
                repeat (5000) @(negedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule